// File: doc/BRIEF.md
# Atomic Lock-Word Operation Unit

This block sits beside a small shared register file of lock words and serves several requesting cores. Each core offers one operation at a time on its own valid/ready port: a load, a store, a test-and-set or a compare-and-swap. The operation names a word address, an expected value and a new value. A round-robin arbiter picks one requester per cycle. The picked operation reads the word, compares it, writes it back and captures the word's old value, all in a single clock edge. No other requester can reach the word between the read and the write.

The response comes back one cycle after the grant. It carries the value the word held before the operation, for every opcode. Software takes a lock in one of two ways: a test-and-set that returns 0, or a compare-and-swap with expected 0 and new 1 that returns 0. It releases the lock by storing 0. Because the arbiter rotates, a core that keeps its request raised is served within NUM_REQ-1 grants to other cores.

Top module: `atomic_unit`

## Requirements
- R1: After reset, every word in the store reads 0.
- R2: Opcode 2'b00 (load) returns the word and leaves it unchanged.
- R3: Opcode 2'b01 (store) writes the new value and returns the prior value.
- R4: Opcode 2'b10 (test-and-set) returns the prior value and leaves the word equal to 1, whatever it held before.
- R5: Opcode 2'b11 (compare-and-swap) whose expected value equals the word writes the new value and returns the prior value.
- R6: A compare-and-swap whose expected value differs from the word leaves the word unchanged and still returns the prior value.
- R7: At most one ready bit is high in any cycle, and ready is only given to a requester whose valid is high.
- R8: A response is valid exactly one cycle after a grant. Its valid bit is set only for the granted requester, and no response follows a cycle with no grant.
- R9: Grants rotate. After requester k is granted, the next grant goes to the first valid requester in the order k+1, k+2, ... wrapping around.
- R10: Operations are indivisible. When two requesters issue test-and-set to the same free word in the same cycle, exactly one of them sees 0 and the other sees 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | NUM_REQ | Per-requester request valid |
| req_ready_o | output | NUM_REQ | Per-requester grant (one-hot or zero) |
| req_op_i | input | NUM_REQ x 2 | Opcode: 00 load, 01 store, 10 test-and-set, 11 compare-and-swap |
| req_addr_i | input | NUM_REQ x ADDR_W | Word address |
| req_cmp_i | input | NUM_REQ x DATA_W | Expected value for compare-and-swap |
| req_wdata_i | input | NUM_REQ x DATA_W | New value for store and compare-and-swap |
| rsp_valid_o | output | NUM_REQ | Per-requester response valid, one cycle after grant |
| rsp_rdata_o | output | DATA_W | Prior word value for the responding requester |

## Verification
The bench aims at the two compare-and-swap outcomes. A design that returns a success flag, or that writes on a mismatch, returns the wrong old value or leaves a corrupted word for the next load to expose. It repeats test-and-set on a word that is already held, which catches a unit that toggles the word or returns the new value instead of the old one. It also fires simultaneous test-and-sets on one free word: a unit that let two operations overlap would hand the lock to both requesters. Finally it keeps all requesters raised to confirm strict rotation, which a fixed-priority arbiter would break by starving the upper indices.

// File: rtl/atomic_pkg.sv
package atomic_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_TAS   = 2'b10,
    OP_CAS   = 2'b11
  } atomic_op_e;
endpackage

// File: rtl/atomic_rr_arb.sv
module atomic_rr_arb #(
  parameter int NUM_REQ = 4,
  localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_REQ-1:0] req_i,
  output logic [NUM_REQ-1:0] gnt_o,
  output logic [IDX_W-1:0]   gnt_idx_o,
  output logic               gnt_any_o
);
  logic [IDX_W-1:0] ptr_q;

  // search starts at ptr_q and wraps
  always_comb begin
    int idx;
    gnt_o     = '0;
    gnt_idx_o = '0;
    gnt_any_o = 1'b0;
    for (int k = 0; k < NUM_REQ; k++) begin
      idx = (int'(ptr_q) + k) % NUM_REQ;
      if (!gnt_any_o && req_i[idx]) begin
        gnt_o[idx] = 1'b1;
        gnt_idx_o  = IDX_W'(idx);
        gnt_any_o  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (gnt_any_o) begin
      if (int'(gnt_idx_o) == NUM_REQ - 1) ptr_q <= '0;
      else                                ptr_q <= gnt_idx_o + 1'b1;
    end
  end
endmodule

// File: rtl/atomic_lock_store.sv
module atomic_lock_store
  import atomic_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16,
  localparam int DEPTH = 2 ** ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  atomic_op_e        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] cmp_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] old_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] nxt_val;
  logic              we;

  assign old_o = mem_q[addr_i];

  always_comb begin
    we      = 1'b0;
    nxt_val = wdata_i;
    unique case (op_i)
      OP_LOAD:  we = 1'b0;
      OP_STORE: we = 1'b1;
      OP_TAS: begin
        we      = 1'b1;
        nxt_val = DATA_W'(1);
      end
      OP_CAS:   we = (old_o == cmp_i);
      default:  we = 1'b0;
    endcase
  end

  // read, compare and write resolve on one edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (en_i && we) begin
      mem_q[addr_i] <= nxt_val;
    end
  end
endmodule

// File: rtl/atomic_unit.sv
module atomic_unit
  import atomic_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_REQ-1:0]             req_valid_i,
  output logic [NUM_REQ-1:0]             req_ready_o,
  input  logic [NUM_REQ-1:0][1:0]        req_op_i,
  input  logic [NUM_REQ-1:0][ADDR_W-1:0] req_addr_i,
  input  logic [NUM_REQ-1:0][DATA_W-1:0] req_cmp_i,
  input  logic [NUM_REQ-1:0][DATA_W-1:0] req_wdata_i,
  output logic [NUM_REQ-1:0]             rsp_valid_o,
  output logic [DATA_W-1:0]              rsp_rdata_o
);
  localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;

  logic [NUM_REQ-1:0] gnt;
  logic [IDX_W-1:0]   gnt_idx;
  logic               gnt_any;
  logic [DATA_W-1:0]  old_val;
  logic [NUM_REQ-1:0] rsp_valid_q;
  logic [DATA_W-1:0]  rsp_rdata_q;

  atomic_rr_arb #(.NUM_REQ(NUM_REQ)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_valid_i),
    .gnt_o     (gnt),
    .gnt_idx_o (gnt_idx),
    .gnt_any_o (gnt_any)
  );

  atomic_lock_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (gnt_any),
    .op_i    (atomic_op_e'(req_op_i[gnt_idx])),
    .addr_i  (req_addr_i[gnt_idx]),
    .cmp_i   (req_cmp_i[gnt_idx]),
    .wdata_i (req_wdata_i[gnt_idx]),
    .old_o   (old_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= '0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= gnt;
      if (gnt_any) rsp_rdata_q <= old_val;
    end
  end

  assign req_ready_o = gnt;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;
endmodule

// File: rtl/atomic_unit_chk.sv
module atomic_unit_chk #(
  parameter int NUM_REQ = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_REQ-1:0] req_valid_i,
  input logic [NUM_REQ-1:0] req_ready_o,
  input logic [NUM_REQ-1:0] rsp_valid_o
);
  a_r7_onehot_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_ready_o));

  a_r7_grant_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o & ~req_valid_i) == '0);

  a_r8_rsp_follows_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o != '0) |=> (rsp_valid_o == $past(req_ready_o)));

  a_r8_no_rsp_unasked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o == '0) |=> (rsp_valid_o == '0));

  a_r9_grant_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i != '0) |-> (req_ready_o != '0));
endmodule

bind atomic_unit atomic_unit_chk #(.NUM_REQ(NUM_REQ)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o)
);

// File: tb/atomic_unit_bench.sv
`timescale 1ns/1ps
module atomic_unit_bench;
  localparam int N  = 4;
  localparam int AW = 3;
  localparam int DW = 16;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic [N-1:0]          req_valid_i = '0;
  logic [N-1:0]          req_ready_o;
  logic [N-1:0][1:0]     req_op_i = '0;
  logic [N-1:0][AW-1:0]  req_addr_i = '0;
  logic [N-1:0][DW-1:0]  req_cmp_i = '0;
  logic [N-1:0][DW-1:0]  req_wdata_i = '0;
  logic [N-1:0]          rsp_valid_o;
  logic [DW-1:0]         rsp_rdata_o;

  int checks = 0;
  int errors = 0;

  atomic_unit #(.NUM_REQ(N), .ADDR_W(AW), .DATA_W(DW)) u_atomic_unit (.*);

  always #2.5 clk_i = ~clk_i;

  typedef struct packed {
    logic [1:0]    rq;
    logic [1:0]    op;
    logic [AW-1:0] addr;
    logic [DW-1:0] cmp;
    logic [DW-1:0] wd;
    logic [DW-1:0] exp;
  } vec_t;

  // op: 00 load, 01 store, 10 tas, 11 cas
  localparam vec_t VECS [14] = '{
    '{2'd0, 2'b00, 3'd3, 16'h0000, 16'h0000, 16'h0000},  // R1
    '{2'd1, 2'b10, 3'd3, 16'h0000, 16'h0000, 16'h0000},  // R4 acquire
    '{2'd2, 2'b10, 3'd3, 16'h0000, 16'h0000, 16'h0001},  // R4 held
    '{2'd3, 2'b00, 3'd3, 16'h0000, 16'h0000, 16'h0001},  // R2
    '{2'd0, 2'b01, 3'd3, 16'h0000, 16'h0000, 16'h0001},  // R3 release
    '{2'd1, 2'b11, 3'd5, 16'h0000, 16'h0001, 16'h0000},  // R5 acquire
    '{2'd2, 2'b11, 3'd5, 16'h0000, 16'h0007, 16'h0001},  // R6 miss
    '{2'd3, 2'b00, 3'd5, 16'h0000, 16'h0000, 16'h0001},  // R6 unchanged
    '{2'd0, 2'b01, 3'd5, 16'h0000, 16'hbeef, 16'h0001},  // R3
    '{2'd1, 2'b11, 3'd5, 16'hbeef, 16'h1234, 16'hbeef},  // R5 wide
    '{2'd2, 2'b00, 3'd5, 16'h0000, 16'h0000, 16'h1234},  // R5 written
    '{2'd3, 2'b00, 3'd2, 16'h0000, 16'h0000, 16'h0000},  // R1 other word
    '{2'd0, 2'b10, 3'd5, 16'h0000, 16'h0000, 16'h1234},  // R4 over value
    '{2'd1, 2'b00, 3'd3, 16'h0000, 16'h0000, 16'h0000}   // R3 released
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_req(input int r, input logic [1:0] op, input logic [AW-1:0] a,
                         input logic [DW-1:0] c, input logic [DW-1:0] w);
    req_op_i[r]    = op;
    req_addr_i[r]  = a;
    req_cmp_i[r]   = c;
    req_wdata_i[r] = w;
    req_valid_i[r] = 1'b1;
  endtask

  initial begin : watchdog
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R7/R8 reset and idle
    chk(req_ready_o == '0, "R7 idle ready", int'(req_ready_o), 0);
    chk(rsp_valid_o == '0, "R8 idle rsp", int'(rsp_valid_o), 0);

    foreach (VECS[i]) begin
      set_req(int'(VECS[i].rq), VECS[i].op, VECS[i].addr, VECS[i].cmp, VECS[i].wd);
      #1;
      chk(req_ready_o == (N'(1) << VECS[i].rq), "R7 single grant", int'(req_ready_o),
          int'(N'(1) << VECS[i].rq));
      @(posedge clk_i);
      #1;
      req_valid_i = '0;
      @(negedge clk_i);
      chk(rsp_valid_o == (N'(1) << VECS[i].rq), "R8 rsp valid", int'(rsp_valid_o),
          int'(N'(1) << VECS[i].rq));
      chk(rsp_rdata_o == VECS[i].exp, "R2-R6 prior value", int'(rsp_rdata_o),
          int'(VECS[i].exp));
    end

    // R8: no response after idle cycle
    @(negedge clk_i);
    chk(rsp_valid_o == '0, "R8 no rsp after idle", int'(rsp_valid_o), 0);

    // R10: two simultaneous test-and-set on free word 6
    begin
      int zeros = 0, ones = 0;
      logic [N-1:0] g;
      set_req(0, 2'b10, 3'd6, '0, '0);
      set_req(2, 2'b10, 3'd6, '0, '0);
      for (int c = 0; c < 2; c++) begin
        #1;
        g = req_ready_o;
        chk($countones(g) == 1, "R10 one grant per cycle", int'(g), 1);
        @(posedge clk_i);
        #1;
        req_valid_i = req_valid_i & ~g;
        @(negedge clk_i);
        chk(rsp_valid_o == g, "R8 rsp to granted", int'(rsp_valid_o), int'(g));
        if (rsp_rdata_o == 16'h0000) zeros++;
        else if (rsp_rdata_o == 16'h0001) ones++;
      end
      chk(zeros == 1 && ones == 1, "R10 exactly one winner", zeros, 1);
    end

    // R9: all requesters raised, grants must rotate
    begin
      int prev = -1;
      int seen = 0;
      for (int r = 0; r < N; r++) set_req(r, 2'b00, 3'd0, '0, '0);
      for (int c = 0; c < 2 * N; c++) begin
        int cur = -1;
        #1;
        for (int r = 0; r < N; r++) if (req_ready_o[r]) cur = r;
        if (prev >= 0)
          chk(cur == (prev + 1) % N, "R9 rotation", cur, (prev + 1) % N);
        if (c < N && cur >= 0) seen = seen | (1 << cur);
        prev = cur;
        @(negedge clk_i);
      end
      chk(seen == (1 << N) - 1, "R9 all served in N grants", seen, (1 << N) - 1);
      req_valid_i = '0;
    end

    // R1: reset clears words written above
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    set_req(3, 2'b00, 3'd5, '0, '0);
    @(posedge clk_i);
    #1;
    req_valid_i = '0;
    @(negedge clk_i);
    chk(rsp_rdata_o == 16'h0000, "R1 cleared after reset", int'(rsp_rdata_o), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule